// File: doc/BRIEF.md
# Trigger Term Bank for a Sampling Logic Analyzer

This block turns a stream of 32-bit sample words into a 16-bit vector of trigger-term results, one vector per valid sample. Four kinds of term are evaluated side by side on every sample. Ten masked equality matches compare selected channels against a pattern. Two window checks test whether the whole word lies inside an unsigned interval. Two transition detectors look for rising, falling or any change on chosen channels, measured against the previous valid sample. Two elapsed-time timers count clock ticks and report once a programmed limit has been reached.

An external sequencer starts, stops and clears the timers through per-timer command pulses. It consumes the registered hit vector, which appears one clock after the sample. Configuration is loaded through a simple word-wide write port. At the intended 100 MHz sample clock, one timer tick is 10 ns, and a 36-bit count spans roughly ten minutes. Combining terms into trigger decisions is left to the sequencer.

Top module: `trig_term_bank`

## Requirements
- R1: `hit_valid` is high exactly one clock after a cycle with `s_valid` high. `hit_vec` is loaded only on valid samples and holds its value on every other cycle.
- R2: Value term i (i = 0..9) is 1 when `(s_data & mask_i) == (pattern_i & mask_i)`. With a zero mask the term is always 1.
- R3: Window term j (j = 0..1) is 1 when `lo_j <= s_data <= hi_j`, with both bounds inclusive and compared as unsigned numbers.
- R4: A window term whose lower bound is greater than its upper bound never reports 1.
- R5: Transition term k (k = 0..1) has a channel mask and a 2-bit mode: 1 = rising (a masked bit goes from 0 to 1), 2 = falling (1 to 0), 3 = either direction.
- R6: Mode 0 turns a transition term off, so its output is always 0.
- R7: Transitions are measured against the previous valid sample, and cycles without `s_valid` are skipped. The first valid sample after reset reports no transition.
- R8: A running timer adds one per clock and saturates at all ones. A stopped timer keeps its count. Timer term t is 1 when its count is at least its 36-bit limit, with the count taken at the sample's clock edge.
- R9: `tmr_start` sets a timer running and wins over `tmr_stop` in the same cycle. `tmr_clear` zeroes the count on the next clock, and that clock adds no increment.
- R10: Bit order of `hit_vec`: bits 0..9 are value terms 0..9, bits 10..11 window terms 0..1, bits 12..13 transition terms 0..1, bits 14..15 timer terms 0..1.
- R11: The configuration word address map is as follows. Value term i uses 2i for the mask and 2i+1 for the pattern. Window j uses 20+2j for lo and 21+2j for hi. Transition k uses 24+2k for the mask and 25+2k for the mode (data bits 1:0). Timer t uses 28+2t for limit bits 31:0 and 29+2t for limit bits 35:32 (data bits 3:0). A write takes effect from the next clock. Reset clears all configuration, counts and outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| s_valid | input | 1 | Sample word valid |
| s_data | input | 32 | Sample word |
| tmr_start | input | 2 | Per-timer start command |
| tmr_stop | input | 2 | Per-timer stop command |
| tmr_clear | input | 2 | Per-timer clear command |
| hit_valid | output | 1 | Hit vector valid, one clock after the sample |
| hit_vec | output | 16 | Registered term results |

## Verification
Some behaviour is checked by the assertions on every clock. These are the one-cycle valid timing and the hold of `hit_vec` between samples. They also cover zero-mask value terms that always match, inverted windows that never match, and transition terms in mode 0 that stay silent. On the timers side, they check that clear zeroes the count, that a start leaves the timer running, and that a stopped timer keeps its count. Other behaviour needs the bench's scenarios, where a scoreboard compares every vector against a model built from the requirements. That covers inclusive window bounds at their exact edges, transition detection across skipped cycles, and the silent first sample after reset. It also covers the timer terms crossing their limit, with start winning over stop in the same cycle.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_mode_e;
endpackage

// File: rtl/trig_val_cmp.sv
module trig_val_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] data,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] pattern,
  output logic         hit
);
  always_comb hit = ((data ^ pattern) & mask) == '0;
endmodule

// File: rtl/trig_range_cmp.sv
module trig_range_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] data,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic         hit
);
  // inclusive unsigned window; an inverted window can never hold
  always_comb hit = (data >= lo) && (data <= hi);
endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det
  import trig_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid,
  input  logic [W-1:0] data,
  input  logic [W-1:0] mask,
  input  logic [1:0]   mode,
  output logic         hit
);
  logic [W-1:0] prev_q;
  logic         prev_ok_q;
  logic         rise, fall;
  edge_mode_e   m;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= '0;
      prev_ok_q <= 1'b0;
    end else if (valid) begin
      prev_q    <= data;
      prev_ok_q <= 1'b1;
    end
  end

  always_comb begin
    m    = edge_mode_e'(mode);
    rise = |(~prev_q & data & mask);
    fall = |(prev_q & ~data & mask);
    unique case (m)
      EDGE_RISE: hit = prev_ok_q && rise;
      EDGE_FALL: hit = prev_ok_q && fall;
      EDGE_ANY:  hit = prev_ok_q && (rise || fall);
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/trig_timer.sv
module trig_timer #(
  parameter int TW = 36
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop,
  input  logic          clear,
  input  logic [TW-1:0] limit,
  output logic [TW-1:0] cnt,
  output logic          run,
  output logic          hit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
    end else begin
      if (start)     run <= 1'b1;
      else if (stop) run <= 1'b0;
      if (clear)                   cnt <= '0;
      else if (run && cnt != '1)   cnt <= cnt + 1'b1;
    end
  end

  always_comb hit = (cnt >= limit);
endmodule

// File: rtl/trig_term_bank.sv
module trig_term_bank #(
  parameter int DATA_W = 32,
  parameter int N_VAL  = 10,
  parameter int N_RNG  = 2,
  parameter int N_EDGE = 2,
  parameter int N_TMR  = 2,
  parameter int TMR_W  = 36,
  parameter int ADDR_W = 6
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cfg_we,
  input  logic [ADDR_W-1:0]               cfg_addr,
  input  logic [DATA_W-1:0]               cfg_wdata,
  input  logic                            s_valid,
  input  logic [DATA_W-1:0]               s_data,
  input  logic [N_TMR-1:0]                tmr_start,
  input  logic [N_TMR-1:0]                tmr_stop,
  input  logic [N_TMR-1:0]                tmr_clear,
  output logic                            hit_valid,
  output logic [N_VAL+N_RNG+N_EDGE+N_TMR-1:0] hit_vec
);
  localparam int N_HIT     = N_VAL + N_RNG + N_EDGE + N_TMR;
  localparam int RNG_BASE  = 2 * N_VAL;
  localparam int EDGE_BASE = RNG_BASE + 2 * N_RNG;
  localparam int TMR_BASE  = EDGE_BASE + 2 * N_EDGE;
  localparam int HI_W      = TMR_W - DATA_W;
  localparam int OFF_RNG   = N_VAL;
  localparam int OFF_EDGE  = N_VAL + N_RNG;
  localparam int OFF_TMR   = N_VAL + N_RNG + N_EDGE;

  logic [N_VAL-1:0][DATA_W-1:0]  val_mask, val_pat;
  logic [N_RNG-1:0][DATA_W-1:0]  rng_lo, rng_hi;
  logic [N_EDGE-1:0][DATA_W-1:0] edge_mask;
  logic [N_EDGE-1:0][1:0]        edge_mode;
  logic [N_TMR-1:0][TMR_W-1:0]   tmr_limit;
  logic [N_TMR-1:0][TMR_W-1:0]   tmr_cnt;
  logic [N_TMR-1:0]              tmr_run;
  logic [N_HIT-1:0]              hit_now;

  for (genvar i = 0; i < N_VAL; i++) begin : g_val
    always_ff @(posedge clk) begin
      if (rst) begin
        val_mask[i] <= '0;
        val_pat[i]  <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == ADDR_W'(2*i))   val_mask[i] <= cfg_wdata;
        if (cfg_addr == ADDR_W'(2*i+1)) val_pat[i]  <= cfg_wdata;
      end
    end
    trig_val_cmp #(.W(DATA_W)) u_cmp (
      .data(s_data), .mask(val_mask[i]), .pattern(val_pat[i]), .hit(hit_now[i])
    );
  end

  for (genvar j = 0; j < N_RNG; j++) begin : g_rng
    always_ff @(posedge clk) begin
      if (rst) begin
        rng_lo[j] <= '0;
        rng_hi[j] <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == ADDR_W'(RNG_BASE+2*j))   rng_lo[j] <= cfg_wdata;
        if (cfg_addr == ADDR_W'(RNG_BASE+2*j+1)) rng_hi[j] <= cfg_wdata;
      end
    end
    trig_range_cmp #(.W(DATA_W)) u_rng (
      .data(s_data), .lo(rng_lo[j]), .hi(rng_hi[j]), .hit(hit_now[OFF_RNG+j])
    );
  end

  for (genvar k = 0; k < N_EDGE; k++) begin : g_edge
    always_ff @(posedge clk) begin
      if (rst) begin
        edge_mask[k] <= '0;
        edge_mode[k] <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == ADDR_W'(EDGE_BASE+2*k))   edge_mask[k] <= cfg_wdata;
        if (cfg_addr == ADDR_W'(EDGE_BASE+2*k+1)) edge_mode[k] <= cfg_wdata[1:0];
      end
    end
    trig_edge_det #(.W(DATA_W)) u_edge (
      .clk(clk), .rst(rst), .valid(s_valid), .data(s_data),
      .mask(edge_mask[k]), .mode(edge_mode[k]), .hit(hit_now[OFF_EDGE+k])
    );
  end

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    always_ff @(posedge clk) begin
      if (rst) begin
        tmr_limit[t] <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == ADDR_W'(TMR_BASE+2*t))
          tmr_limit[t][DATA_W-1:0] <= cfg_wdata;
        if (cfg_addr == ADDR_W'(TMR_BASE+2*t+1))
          tmr_limit[t][TMR_W-1:DATA_W] <= cfg_wdata[HI_W-1:0];
      end
    end
    trig_timer #(.TW(TMR_W)) u_tmr (
      .clk(clk), .rst(rst), .start(tmr_start[t]), .stop(tmr_stop[t]),
      .clear(tmr_clear[t]), .limit(tmr_limit[t]), .cnt(tmr_cnt[t]),
      .run(tmr_run[t]), .hit(hit_now[OFF_TMR+t])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_valid <= 1'b0;
      hit_vec   <= '0;
    end else begin
      hit_valid <= s_valid;
      if (s_valid) hit_vec <= hit_now;
    end
  end
endmodule

// File: rtl/trig_term_bank_chk.sv
module trig_term_bank_chk #(
  parameter int DATA_W = 32,
  parameter int N_VAL  = 10,
  parameter int N_RNG  = 2,
  parameter int N_EDGE = 2,
  parameter int N_TMR  = 2,
  parameter int TMR_W  = 36,
  parameter int N_HIT  = 16
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           s_valid,
  input logic                           hit_valid,
  input logic [N_HIT-1:0]               hit_vec,
  input logic [N_VAL-1:0][DATA_W-1:0]   val_mask,
  input logic [N_RNG-1:0][DATA_W-1:0]   rng_lo,
  input logic [N_RNG-1:0][DATA_W-1:0]   rng_hi,
  input logic [N_EDGE-1:0][1:0]         edge_mode,
  input logic [N_TMR-1:0]               tmr_start,
  input logic [N_TMR-1:0]               tmr_clear,
  input logic [N_TMR-1:0]               tmr_run,
  input logic [N_TMR-1:0][TMR_W-1:0]    tmr_cnt
);
  localparam int OFF_RNG  = N_VAL;
  localparam int OFF_EDGE = N_VAL + N_RNG;

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    s_valid |=> hit_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !s_valid |=> !hit_valid);
  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    !s_valid |=> $stable(hit_vec));

  for (genvar i = 0; i < N_VAL; i++) begin : g_v
    a_r2_zero_mask: assert property (@(posedge clk) disable iff (rst)
      (s_valid && val_mask[i] == '0) |=> hit_vec[i]);
  end

  for (genvar j = 0; j < N_RNG; j++) begin : g_r
    a_r4_inverted: assert property (@(posedge clk) disable iff (rst)
      (s_valid && rng_lo[j] > rng_hi[j]) |=> !hit_vec[OFF_RNG+j]);
  end

  for (genvar k = 0; k < N_EDGE; k++) begin : g_e
    a_r6_off_mode: assert property (@(posedge clk) disable iff (rst)
      (s_valid && edge_mode[k] == 2'd0) |=> !hit_vec[OFF_EDGE+k]);
  end

  for (genvar t = 0; t < N_TMR; t++) begin : g_t
    a_r9_clear_zero: assert property (@(posedge clk) disable iff (rst)
      tmr_clear[t] |=> (tmr_cnt[t] == '0));
    a_r9_start_runs: assert property (@(posedge clk) disable iff (rst)
      tmr_start[t] |=> tmr_run[t]);
    a_r8_stopped_holds: assert property (@(posedge clk) disable iff (rst)
      (!tmr_run[t] && !tmr_clear[t]) |=> $stable(tmr_cnt[t]));
  end
endmodule

bind trig_term_bank trig_term_bank_chk #(
  .DATA_W(DATA_W), .N_VAL(N_VAL), .N_RNG(N_RNG), .N_EDGE(N_EDGE),
  .N_TMR(N_TMR), .TMR_W(TMR_W), .N_HIT(N_VAL+N_RNG+N_EDGE+N_TMR)
) u_chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .hit_valid(hit_valid),
  .hit_vec(hit_vec), .val_mask(val_mask), .rng_lo(rng_lo), .rng_hi(rng_hi),
  .edge_mode(edge_mode), .tmr_start(tmr_start), .tmr_clear(tmr_clear),
  .tmr_run(tmr_run), .tmr_cnt(tmr_cnt)
);

// File: tb/tb_trig_term_bank.sv
module tb_trig_term_bank;
  localparam int NV = 10, NR = 2, NE = 2, NT = 2, NH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic [1:0]  tmr_start = '0, tmr_stop = '0, tmr_clear = '0;
  logic        hit_valid;
  logic [15:0] hit_vec;

  int errors = 0;
  int checks = 0;

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t sb_q[$];

  logic [31:0] m_vmask [NV];
  logic [31:0] m_vpat  [NV];
  logic [31:0] m_lo [NR];
  logic [31:0] m_hi [NR];
  logic [31:0] m_emask [NE];
  logic [1:0]  m_emode [NE];
  logic [35:0] m_lim [NT];
  logic [35:0] m_cnt [NT];
  logic        m_run [NT];
  logic [31:0] m_prev;
  logic        m_prev_ok;
  logic [15:0] last_exp;

  trig_term_bank dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .s_valid(s_valid), .s_data(s_data),
    .tmr_start(tmr_start), .tmr_stop(tmr_stop), .tmr_clear(tmr_clear),
    .hit_valid(hit_valid), .hit_vec(hit_vec)
  );

  always #2 clk = ~clk;

  // timer model (R8, R9)
  always @(posedge clk) begin
    for (int t = 0; t < NT; t++) begin
      if (rst) begin
        m_cnt[t] <= '0;
        m_run[t] <= 1'b0;
      end else begin
        if (tmr_start[t])     m_run[t] <= 1'b1;
        else if (tmr_stop[t]) m_run[t] <= 1'b0;
        if (tmr_clear[t])                      m_cnt[t] <= '0;
        else if (m_run[t] && m_cnt[t] != '1)   m_cnt[t] <= m_cnt[t] + 36'd1;
      end
    end
  end

  function automatic logic [15:0] model(input logic [31:0] d);
    logic [15:0] v;
    logic [31:0] r, f;
    v = '0;
    for (int i = 0; i < NV; i++) v[i] = ((d & m_vmask[i]) == (m_vpat[i] & m_vmask[i]));
    for (int j = 0; j < NR; j++) v[10+j] = (d >= m_lo[j]) && (d <= m_hi[j]);
    for (int k = 0; k < NE; k++) begin
      r = ~m_prev & d & m_emask[k];
      f = m_prev & ~d & m_emask[k];
      case (m_emode[k])
        2'd1: v[12+k] = m_prev_ok && (r != 0);
        2'd2: v[12+k] = m_prev_ok && (f != 0);
        2'd3: v[12+k] = m_prev_ok && ((r | f) != 0);
        default: v[12+k] = 1'b0;
      endcase
    end
    for (int t = 0; t < NT; t++) v[14+t] = (m_cnt[t] >= m_lim[t]);
    return v;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (!rst && hit_valid) begin
      if (sb_q.size() == 0) check("R1 unexpected", 16'h0001, 16'h0000);
      else begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, hit_vec, it.exp);
      end
    end
  end

  task automatic send(input logic [31:0] d, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = model(d);
    it.tag = tag;
    sb_q.push_back(it);
    last_exp = it.exp;
    m_prev = d;
    m_prev_ok = 1'b1;
    s_valid = 1'b1;
    s_data = d;
    @(negedge clk);
    s_valid = 1'b0;
    s_data = 32'hDEAD_BEEF;
  endtask

  task automatic cfg(input int a, input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = 6'(a);
    cfg_wdata = w;
    if (a < 20) begin
      if (a % 2 == 0) m_vmask[a/2] = w; else m_vpat[a/2] = w;
    end else if (a < 24) begin
      if (a % 2 == 0) m_lo[(a-20)/2] = w; else m_hi[(a-20)/2] = w;
    end else if (a < 28) begin
      if (a % 2 == 0) m_emask[(a-24)/2] = w; else m_emode[(a-24)/2] = w[1:0];
    end else begin
      if (a % 2 == 0) m_lim[(a-28)/2][31:0] = w; else m_lim[(a-28)/2][35:32] = w[3:0];
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic tcmd(input logic [1:0] st, input logic [1:0] sp, input logic [1:0] cl);
    @(negedge clk);
    tmr_start = st; tmr_stop = sp; tmr_clear = cl;
    @(negedge clk);
    tmr_start = '0; tmr_stop = '0; tmr_clear = '0;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NV; i++) begin m_vmask[i] = '0; m_vpat[i] = '0; end
    for (int j = 0; j < NR; j++) begin m_lo[j] = '0; m_hi[j] = '0; end
    for (int k = 0; k < NE; k++) begin m_emask[k] = '0; m_emode[k] = '0; end
    for (int t = 0; t < NT; t++) m_lim[t] = '0;
    m_prev = '0;
    m_prev_ok = 1'b0;
    last_exp = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 reset hit_valid", {15'd0, hit_valid}, 16'h0000);
    check("R11 reset hit_vec", hit_vec, 16'h0000);

    // R7: transitions configured before the first sample must stay silent
    cfg(24, 32'hFFFF_FFFF); cfg(25, 32'd1);
    cfg(26, 32'hFFFF_FFFF); cfg(27, 32'd3);
    send(32'hFFFF_FFFF, "R7 first sample");
    send(32'h0000_0000, "R5 any-edge fall");
    // R1 hold between samples
    repeat (3) @(negedge clk);
    check("R1 hold", hit_vec, last_exp);

    // defaults: zero masks, window [0,0], timers limit 0 (R2 R3 R8 R10)
    send(32'h0000_0000, "R10 defaults zero");
    send(32'h0000_0005, "R10 defaults nonzero");

    // R2 value terms
    for (int i = 0; i < NV; i++) begin
      cfg(2*i, 32'h0000_00FF << (i % 4) * 8);
      cfg(2*i+1, 32'h1111_1111 * i);
    end
    send(32'h3333_3333, "R2 match pattern 3");
    send(32'h0000_0055, "R2 partial");
    send(32'h9999_9999, "R2 match pattern 9");
    send(32'h1111_1111, "R2 match pattern 1");

    // R3 R4 windows
    cfg(20, 32'd100); cfg(21, 32'd200);
    cfg(22, 32'd300); cfg(23, 32'd10);
    send(32'd99, "R3 below lo");
    send(32'd100, "R3 at lo");
    send(32'd200, "R3 at hi");
    send(32'd201, "R3 above hi");
    send(32'd150, "R4 inverted window");
    cfg(22, 32'h8000_0000); cfg(23, 32'hFFFF_FFFF);
    send(32'h7FFF_FFFF, "R3 unsigned below");
    send(32'hFFFF_FFFF, "R3 unsigned top");

    // R5 R6 R7 transitions
    cfg(24, 32'h0000_0001); cfg(25, 32'd1);
    cfg(26, 32'h0000_0002); cfg(27, 32'd2);
    send(32'h0000_0002, "R5 setup");
    send(32'h0000_0001, "R5 rise and fall");
    send(32'h0000_0100, "R5 unmasked change");
    repeat (4) @(negedge clk);
    send(32'h0000_0101, "R7 skipped cycles");
    cfg(25, 32'd0); cfg(27, 32'd3);
    send(32'h0000_0002, "R6 off mode");
    send(32'h0000_0000, "R6 off and any");

    // R8 R9 timers
    cfg(28, 32'd20); cfg(29, 32'd0);
    cfg(30, 32'd0);  cfg(31, 32'd1);
    send(32'd0, "R8 below limit");
    tcmd(2'b11, 2'b00, 2'b00);
    for (int n = 0; n < 12; n++) send(32'(n), "R8 counting");
    tcmd(2'b01, 2'b01, 2'b00);
    send(32'd1, "R9 start over stop");
    tcmd(2'b00, 2'b01, 2'b00);
    send(32'd2, "R8 stopped");
    repeat (5) @(negedge clk);
    send(32'd3, "R8 stopped holds");
    tcmd(2'b00, 2'b00, 2'b01);
    send(32'd4, "R9 cleared");
    tcmd(2'b01, 2'b00, 2'b01);
    for (int n = 0; n < 12; n++) send(32'(n), "R9 clear with start");

    repeat (4) @(negedge clk);
    if (sb_q.size() != 0) check("R1 pending results", 16'(sb_q.size()), 16'h0000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule